// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block sends audio sample words one bit at a time on a single data line. The line is framed by a word clock and timed by a bit clock. Both clocks come from outside, so the block runs as a slave. It samples both clocks with its own system clock and finds bit-clock edges by comparing each value with the one from the previous cycle. On every active bit-clock edge it looks at the word clock. A change in the word clock starts a new phase. In dual-phase mode each level of the word clock carries one word. In single-phase mode only a rising word-clock edge starts a word, which gives one word per frame.

A delay setting places the first data bit at a programmable number of bit-clock periods after the word-clock edge. A delay of 0 gives left-justified or DSP timing, 1 gives I2S timing, and a larger value gives right-justified placement. A word-length setting, a memory-width setting and an edge-select setting complete the configuration. The configuration is captured once per frame, on the rising word-clock edge. Samples arrive over a valid/ready handshake, one transfer at the start of each phase.

Top module: `sai_tx`

## Requirements
- R1: After reset, `dout` and `underrun` are 0 and `inReady` stays 0 while the bit clock does not toggle. The active configuration resets to word length 16, dual-phase, rising-edge sampling, 16-bit memory width and delay 1.
- R2: Let index k count active bit-clock edges, with k=0 being the edge on which the word-clock change is seen. With delay D and word length L, the bit sampled at index k for D <= k < D+L is bit (23-(k-D)) of the 24-bit left-aligned word, so the word goes out MSB first.
- R3: When D is not 0, `dout` is 0 at every index outside the window D..D+L-1.
- R4: When D is 0, outside the window `dout` carries bit 23 of the aligned pending input word when `inValid` is 1, and 0 otherwise.
- R5: When `cfgSampleRise` is 1, the word clock is sampled on rising bit-clock edges and `dout` changes after falling edges. When it is 0 the two edges are swapped.
- R6: When `cfgDualPhase` is 1, both word-clock edges start a phase, and the rising edge starts phase 0. When it is 0, only the rising edge starts a phase, and one word is sent per frame.
- R7: A word length below 8 acts as 8, and a word length above 24 acts as 24.
- R8: When `cfgMem24` is 0, bits 15:0 of `inData` form the top of the aligned word and 8 zero bits fill the bottom. When it is 1, all 24 bits are used. Only the top L bits are sent, so a longer memory word is truncated at its LSBs and a shorter one is padded with zeros.
- R9: `inReady` is high for exactly the clock cycle in which a phase-start edge is first seen. A word transfers when `inValid` is also 1 in that cycle.
- R10: If `inValid` is 0 at a phase start, the phase sends zeros, no word is consumed, and `underrun` pulses high for one cycle on the next clock.
- R11: Configuration inputs take effect only at a rising word-clock edge. A change in the middle of a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the external master |
| wclk | input | 1 | Word clock (frame sync) from the external master |
| cfgWordLen | input | 5 | Serial word length in bits, clamped to 8..24 |
| cfgDelay | input | 8 | Bit-clock periods from the word-clock edge to the MSB |
| cfgSampleRise | input | 1 | 1: sample on rising edges, drive on falling edges |
| cfgDualPhase | input | 1 | 1: one word per word-clock level; 0: one word per frame |
| cfgMem24 | input | 1 | 1: 24-bit memory word; 0: 16-bit memory word in bits 15:0 |
| inData | input | 24 | Sample word |
| inValid | input | 1 | Sample word is valid |
| inReady | output | 1 | Word taken in this cycle (phase start) |
| dout | output | 1 | Serial data line |
| underrun | output | 1 | One-cycle pulse when a phase starts with no valid word |

## Verification
The bench sweeps word lengths that include both clamp cases, the three kinds of delay (0, 1, and right-justified at the frame end), both memory widths, both edge settings and both phase modes. For every bit of every phase it compares the data line against an arithmetic model of the receiver. A design that pre-drives while the delay is nonzero, or that fails to pre-drive the next MSB when the delay is 0, shows a wrong bit at index 0 or after the LSB. Wrong alignment or wrong clamping shows up as shifted or missing bits in the window. A design that applies a new delay in the middle of a frame, consumes a word on an underrun, or samples on the wrong bit-clock edge gives phases that mismatch the model.

// File: rtl/sai_tx_pkg.sv
`timescale 1ns/1ps
package sai_tx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int NARROW_W = 16;
  localparam int LEN_W    = 5;
  localparam int DLY_W    = 8;
  localparam int CNT_W    = 9;
  localparam int POS_W    = CNT_W + 1;
  localparam int IDX_W    = $clog2(SAMPLE_W);
  localparam int LEN_MIN  = 8;
  localparam int LEN_MAX  = SAMPLE_W;

  typedef struct packed {
    logic [LEN_W-1:0] wordLen;
    logic [DLY_W-1:0] delay;
    logic             sampleRise;
    logic             dualPhase;
    logic             mem24;
  } cfg_t;

  typedef struct packed {
    logic             load;
    logic             drive;
    logic [POS_W-1:0] pos;
  } strobe_t;

  localparam cfg_t CFG_RESET = '{wordLen: LEN_W'(16), delay: DLY_W'(1),
                                 sampleRise: 1'b1, dualPhase: 1'b1, mem24: 1'b0};

  function automatic logic [SAMPLE_W-1:0] alignWord(logic [SAMPLE_W-1:0] d, logic wide);
    return wide ? d : {d[NARROW_W-1:0], {(SAMPLE_W-NARROW_W){1'b0}}};
  endfunction
endpackage

// File: rtl/sai_tx_ctrl.sv
`timescale 1ns/1ps
module sai_tx_ctrl
  import sai_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bclk,
  input  logic    wclk,
  input  cfg_t    cfgIn,
  output cfg_t    cfgAct,
  output cfg_t    cfgNow,
  output strobe_t strb
);
  logic             bclkPrev;
  logic             wclkLast;
  logic [CNT_W-1:0] cnt;
  cfg_t             cfgLoad;
  logic             rise, fall, sampleEv, driveEv, wRise, wFall, phaseStart;

  always_comb begin
    cfgLoad = cfgIn;
    if (cfgIn.wordLen < LEN_W'(LEN_MIN))      cfgLoad.wordLen = LEN_W'(LEN_MIN);
    else if (cfgIn.wordLen > LEN_W'(LEN_MAX)) cfgLoad.wordLen = LEN_W'(LEN_MAX);
  end

  assign rise       = bclk & ~bclkPrev;
  assign fall       = ~bclk & bclkPrev;
  assign sampleEv   = cfgAct.sampleRise ? rise : fall;
  assign driveEv    = cfgAct.sampleRise ? fall : rise;
  assign wRise      = sampleEv & wclk & ~wclkLast;
  assign wFall      = sampleEv & ~wclk & wclkLast;
  assign phaseStart = wRise | (wFall & cfgAct.dualPhase);
  assign cfgNow     = wRise ? cfgLoad : cfgAct;

  assign strb.load  = phaseStart;
  assign strb.drive = driveEv;
  assign strb.pos   = POS_W'(cnt) + POS_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      wclkLast <= 1'b0;
      cnt      <= '1;
      cfgAct   <= CFG_RESET;
    end else begin
      bclkPrev <= bclk;
      if (sampleEv) begin
        wclkLast <= wclk;
        if (phaseStart)  cnt <= '0;
        else if (cnt != '1) cnt <= cnt + CNT_W'(1);
      end
      if (wRise) cfgAct <= cfgLoad;
    end
  end
endmodule

// File: rtl/sai_tx_dp.sv
`timescale 1ns/1ps
module sai_tx_dp
  import sai_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  cfg_t                cfg,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inValid,
  output logic                dout,
  output logic                underrun
);
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] pending;
  logic [POS_W-1:0]    off;
  logic [IDX_W-1:0]    idx;
  logic                inWin, bitNext;

  assign pending = alignWord(inData, cfg.mem24);
  assign off     = strb.pos - POS_W'(cfg.delay);
  assign inWin   = (strb.pos >= POS_W'(cfg.delay)) && (off < POS_W'(cfg.wordLen));
  assign idx     = IDX_W'(SAMPLE_W - 1) - off[IDX_W-1:0];

  always_comb begin
    if (inWin)                bitNext = word[idx];
    else if (cfg.delay == '0) bitNext = inValid & pending[SAMPLE_W-1];
    else                      bitNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word     <= '0;
      dout     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= strb.load & ~inValid;
      if (strb.load)  word <= inValid ? pending : '0;
      if (strb.drive) dout <= bitNext;
    end
  end
endmodule

// File: rtl/sai_tx.sv
`timescale 1ns/1ps
module sai_tx
  import sai_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclk,
  input  logic                wclk,
  input  logic [LEN_W-1:0]    cfgWordLen,
  input  logic [DLY_W-1:0]    cfgDelay,
  input  logic                cfgSampleRise,
  input  logic                cfgDualPhase,
  input  logic                cfgMem24,
  input  logic [SAMPLE_W-1:0] inData,
  input  logic                inValid,
  output logic                inReady,
  output logic                dout,
  output logic                underrun
);
  cfg_t    cfgIn, cfgAct, cfgNow;
  strobe_t strb;

  assign cfgIn = '{wordLen: cfgWordLen, delay: cfgDelay, sampleRise: cfgSampleRise,
                   dualPhase: cfgDualPhase, mem24: cfgMem24};

  sai_tx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .bclk(bclk), .wclk(wclk),
    .cfgIn(cfgIn), .cfgAct(cfgAct), .cfgNow(cfgNow), .strb(strb)
  );

  sai_tx_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfgNow),
    .inData(inData), .inValid(inValid), .dout(dout), .underrun(underrun)
  );

  assign inReady = strb.load;
endmodule

// File: rtl/sai_tx_chk.sv
`timescale 1ns/1ps
module sai_tx_chk
  import sai_tx_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic bclk,
  input logic wclk,
  input logic inValid,
  input logic inReady,
  input logic dout,
  input logic underrun,
  input cfg_t cfgAct
);
  AST_READY_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (bclk != $past(bclk))); // R9
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun); // R10
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(inReady && !inValid)); // R10
  AST_DOUT_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dout) |-> ($past(bclk) != $past(bclk, 2))); // R5
  AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgAct) |-> $past(inReady && wclk)); // R11
endmodule

bind sai_tx sai_tx_chk uChk (
  .clk(clk), .rstN(rstN), .bclk(bclk), .wclk(wclk), .inValid(inValid),
  .inReady(inReady), .dout(dout), .underrun(underrun), .cfgAct(cfgAct)
);

// File: tb/sai_tx_test.sv
`timescale 1ns/1ps
module sai_tx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclk = 1'b1;
  logic        wclk = 1'b0;
  logic [4:0]  cfgWordLen = 5'd16;
  logic [7:0]  cfgDelay = 8'd1;
  logic        cfgSampleRise = 1'b1;
  logic        cfgDualPhase = 1'b1;
  logic        cfgMem24 = 1'b0;
  logic [23:0] inData = '0;
  logic        inValid = 1'b1;
  logic        inReady, dout, underrun;

  int checks = 0;
  int errors = 0;
  int urCount = 0;
  int n = 0;
  bit done = 0;
  bit samplePol = 1'b1;
  logic wPrev = 1'b0;
  localparam int P = 32;

  always #2.5 clk = ~clk;

  sai_tx uut (
    .clk(clk), .rstN(rstN), .bclk(bclk), .wclk(wclk),
    .cfgWordLen(cfgWordLen), .cfgDelay(cfgDelay), .cfgSampleRise(cfgSampleRise),
    .cfgDualPhase(cfgDualPhase), .cfgMem24(cfgMem24),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .dout(dout), .underrun(underrun)
  );

  always @(negedge clk) if (rstN && underrun) urCount++;

  function automatic logic [23:0] smp(int i);
    logic [31:0] v;
    v = (32'(i) + 32'd1) * 32'h00A5_F3C7 ^ 32'h005A_1C3B;
    return v[23:0];
  endfunction

  function automatic logic [23:0] alignB(logic [23:0] d, bit wide);
    return wide ? d : {d[15:0], 8'h00};
  endfunction

  function automatic int clampL(int l);
    return (l < 8) ? 8 : ((l > 24) ? 24 : l);
  endfunction

  task automatic waitN(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One frame as seen by a receiver; checks each phase bit by bit against the model
  task automatic runFrame(bit doChk, int chgAt, logic [7:0] chgDly);
    bit   fDual = cfgDualPhase;
    int   fD    = int'(cfgDelay);
    int   fL    = clampL(int'(cfgWordLen));
    bit   fMem  = cfgMem24;
    bit   pend  = cfgSampleRise;
    int   nPer  = fDual ? 2 * P : P;
    int   k = 0;
    int   bad = 0;
    int   badK = 0;
    logic badAct = 1'b0;
    logic badExp = 1'b0;
    logic [23:0] cur = '0;
    for (int p = 0; p < nPer; p++) begin
      logic wN;
      logic e;
      logic [23:0] nx;
      bit rose, fell, ps;
      wN   = fDual ? (p < P) : (p == 0);
      rose = wN && !wPrev;
      fell = !wN && wPrev;
      ps   = rose || (fell && fDual);
      bclk = samplePol ? 1'b0 : 1'b1;
      wclk = wN;
      waitN(4);
      if (ps) begin
        k = 0; bad = 0;
        cur = inValid ? alignB(smp(n), fMem) : 24'h0;
      end else k++;
      nx = alignB(inData, fMem);
      if (k >= fD && k < fD + fL) e = cur[23 - (k - fD)];
      else if (fD == 0)          e = inValid & nx[23];
      else                       e = 1'b0;
      if (dout !== e) begin
        if (bad == 0) begin badK = k; badAct = dout; badExp = e; end
        bad++;
      end
      bclk = samplePol ? 1'b1 : 1'b0;
      waitN(4);
      if (ps && inValid) begin n++; inData = smp(n); end
      if (rose) samplePol = pend;
      wPrev = wN;
      if (p == chgAt) cfgDelay = chgDly;
      if (doChk && (p % P) == P - 1) begin
        string tag;
        if (badK >= fD && badK < fD + fL) tag = fMem ? "R2" : "R8";
        else tag = (fD == 0) ? "R4" : "R3";
        checks++;
        if (bad != 0) begin
          errors++;
          $display("FAIL %s (R5 R6 R7 cfg L=%0d D=%0d dual=%0d rise=%0d m24=%0d) bit %0d: actual %b expected %b",
                   tag, fL, fD, fDual, pend, fMem, badK, badAct, badExp);
        end
      end
    end
  endtask

  initial begin
    int wls[6] = '{8, 13, 16, 24, 5, 31};
    int u0;
    inData = smp(0);
    waitN(3);
    rstN = 1'b1;
    waitN(3);
    // R1: outputs idle after reset, R9: no ready without bit-clock edges
    check(dout == 1'b0, "R1 dout after reset", int'(dout), 0);
    check(underrun == 1'b0, "R1 underrun after reset", int'(underrun), 0);
    check(inReady == 1'b0, "R9 ready idle", int'(inReady), 0);
    // R1: default active config (rising sampling) frames the first frame
    runFrame(1, -1, 8'd0);

    // Sweep: R5 edge select, R6 phase mode, R7 clamp, R8 width, R2 R3 R4 placement
    for (int dm = 1; dm >= 0; dm--)
      for (int pl = 1; pl >= 0; pl--)
        for (int mw = 0; mw < 2; mw++)
          for (int wi = 0; wi < 6; wi++)
            for (int di = 0; di < 3; di++) begin
              cfgDualPhase  = dm[0];
              cfgSampleRise = pl[0];
              cfgMem24      = mw[0];
              cfgWordLen    = 5'(wls[wi]);
              cfgDelay      = (di == 2) ? 8'(P - clampL(wls[wi])) : 8'(di);
              runFrame(0, -1, 8'd0);
              runFrame(1, -1, 8'd0);
            end

    // R11: delay changed mid-frame must not affect the running frame
    cfgDualPhase = 1'b1; cfgSampleRise = 1'b1; cfgMem24 = 1'b0;
    cfgWordLen = 5'd16; cfgDelay = 8'd1;
    runFrame(0, -1, 8'd0);
    runFrame(1, 5, 8'd2);   // R11 old delay kept in this frame
    runFrame(1, -1, 8'd0);  // R11 new delay from the next frame

    // R10: underrun sends zeros, pulses the flag per phase, consumes nothing
    cfgDelay = 8'd1;
    runFrame(0, -1, 8'd0);
    inValid = 1'b0;
    u0 = urCount;
    runFrame(1, -1, 8'd0);
    check(urCount - u0 == 2, "R10 underrun pulses", urCount - u0, 2);
    inValid = 1'b1;
    runFrame(1, -1, 8'd0);  // R10 same word sequence resumes
    check(urCount - u0 == 2, "R10 no pulse when valid", urCount - u0, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule